// File: doc/BRIEF.md
# Interrupt Dispatch Controller

This block arbitrates the interrupt requests of a small 8-bit processor core. It collects request pulses from five peripheral sources and latches them in a request-flag register. It also holds a per-source enable register and the master interrupt enable. The flags are indexed by bit: bit 0 is vertical blank, bit 1 is LCD status, bit 2 is timer, bit 3 is serial and bit 4 is joypad. Software reaches both registers through a byte-wide read/write port decoded on a 16-bit address.

Just before each instruction fetch the core raises a check strobe. If the master enable is set and some source has both its flag and its enable bit at 1, the block takes that source. In the same clock edge it clears the source's flag and drops the master enable. It then runs a short fixed sequence. First it asks the core to push its program counter. In the next cycle it presents the source's fixed vector address with the load strobe and reports the dispatch cost of 20 clocks. The core owns instruction decode, the stack memory and the return path.

Top module: `intr_dispatch`

## Requirements
- R1: After reset the flag register, the enable register and the master enable are all 0, and neither pushPc nor loadPc is asserted.
- R2: A read at 0xFF0F returns the five flags in bits 4..0, with bits 7..5 read as 1. A read at 0xFFFF returns the five enables in bits 4..0, with bits 7..5 read as 0. Every other address reads 0. Reads are combinational.
- R3: A write to 0xFF0F or 0xFFFF loads bits 4..0 of the data into that register on the clock edge. A peripheral request pulse on bit i sets flag i on the same edge, and it wins over a software write of 0 to that bit.
- R4: A dispatch starts only in a cycle where checkReq is 1, the master enable is 1, no dispatch sequence is running, and at least one bit is set in both the flag and enable registers. Otherwise nothing is dispatched and no state changes because of checkReq.
- R5: When several sources qualify, the lowest-numbered bit is served.
- R6: The vector for source i is 0x40 + 8*i, so 0x40, 0x48, 0x50, 0x58 and 0x60. It is driven on vectorAddr while loadPc is 1 and is 0 otherwise.
- R7: On the edge that starts a dispatch, the served flag is cleared and the other flags keep their values, apart from any peripheral sets on that edge. This clear wins over a same-cycle software write of 1 to that bit.
- R8: On the edge that starts a dispatch, the master enable becomes 0, even if imeSet is 1 in that cycle.
- R9: pushPc is 1 for exactly the one cycle after the starting edge, and loadPc is 1 for exactly the cycle after that.
- R10: dispatchCost reads 20, which is 5 machine cycles of 4 clocks, while loadPc is 1, and 0 otherwise.
- R11: checkReq has no effect while pushPc or loadPc is 1.
- R12: imeSet sets the master enable and imeClr clears it. When both are 1, the clear wins. The master enable is visible on imeOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Register port address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| periphReq | input | 5 | Request pulses from the five sources |
| imeSet | input | 1 | Set master enable |
| imeClr | input | 1 | Clear master enable |
| checkReq | input | 1 | Core is about to fetch; check for a pending interrupt |
| imeOut | output | 1 | Current master enable |
| pushPc | output | 1 | Core should push its program counter |
| loadPc | output | 1 | Core should load vectorAddr into its program counter |
| vectorAddr | output | 16 | Vector of the served source |
| dispatchCost | output | 8 | Clock cost of the dispatch, valid with loadPc |

## Verification
The bench uses the default parameters: five sources, a vector base of 0x40 with a step of 8, and five machine cycles of four clocks each. With these values all five vectors and the 20-clock cost can be checked directly. A short random phase then makes every pair of competing sources likely. The same random phase also covers same-cycle collisions: a peripheral set against a software clear, a dispatch clear against a software set, and imeSet against a dispatch.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;

  // Dispatch sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } dispState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;    // accept the winning source on this edge
    logic pushPc;  // push phase active
    logic loadPc;  // vector load phase active
  } dispStrobe_t;

endpackage

// File: rtl/intr_dispatch_dp.sv
module intr_dispatch_dp
  import intr_dispatch_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int VEC_W     = 16,
  parameter int FLAG_ADDR = 'hFF0F,
  parameter int MASK_ADDR = 'hFFFF,
  parameter int VEC_BASE  = 'h40,
  parameter int VEC_STEP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] periphReq,
  input  logic               imeSet,
  input  logic               imeClr,
  input  dispStrobe_t        strobe,
  output logic               anyPending,
  output logic               imeQ,
  output logic [VEC_W-1:0]   vectorAddr
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] flagsQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] pendOH;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   winIdxQ;
  logic               wrFlag;
  logic               wrMask;

  assign wrFlag     = regWrEn && (regAddr == ADDR_W'(FLAG_ADDR));
  assign wrMask     = regWrEn && (regAddr == ADDR_W'(MASK_ADDR));
  assign pend       = flagsQ & maskQ;
  assign anyPending = |pend;
  assign pendOH     = pend & (~pend + NUM_SRC'(1));

  // lowest set bit wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) winIdx = IDX_W'(i);
    end
  end

  // per-source flag bit: peripheral set > dispatch clear > software write
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flagsQ[g] <= 1'b0;
      end else if (periphReq[g]) begin
        flagsQ[g] <= 1'b1;
      end else if (strobe.take && pendOH[g]) begin
        flagsQ[g] <= 1'b0;
      end else if (wrFlag) begin
        flagsQ[g] <= regWrData[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ <= '0;
    end else if (wrMask) begin
      maskQ <= regWrData[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imeQ <= 1'b0;
    end else if (strobe.take || imeClr) begin
      imeQ <= 1'b0;
    end else if (imeSet) begin
      imeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winIdxQ <= '0;
    end else if (strobe.take) begin
      winIdxQ <= winIdx;
    end
  end

  always_comb begin
    if (strobe.loadPc) vectorAddr = VEC_W'(VEC_BASE + int'(winIdxQ) * VEC_STEP);
    else               vectorAddr = '0;
  end

  always_comb begin
    if (regAddr == ADDR_W'(FLAG_ADDR))      regRdData = {{PAD_W{1'b1}}, flagsQ};
    else if (regAddr == ADDR_W'(MASK_ADDR)) regRdData = {{PAD_W{1'b0}}, maskQ};
    else                                    regRdData = '0;
  end

  // R8: the edge that takes a source leaves the master enable low
  assert_ime_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> !imeQ);

  // R7: the served flag is gone after the taking edge unless re-requested
  assert_served_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.take && !(|(periphReq & pendOH))) |=> !(|(flagsQ & $past(pendOH))));

  // R3: a peripheral pulse always lands in the flag register
  assert_periph_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|periphReq) |=> ((flagsQ & $past(periphReq)) == $past(periphReq)));

endmodule

// File: rtl/intr_dispatch_ctrl.sv
module intr_dispatch_ctrl
  import intr_dispatch_pkg::*;
#(
  parameter int CLK_PER_MCYC  = 4,
  parameter int DISPATCH_MCYC = 5,
  parameter int COST_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              checkReq,
  input  logic              imeQ,
  input  logic              anyPending,
  output dispStrobe_t       strobe,
  output logic [COST_W-1:0] dispatchCost
);

  localparam int DISPATCH_CLKS = CLK_PER_MCYC * DISPATCH_MCYC;

  dispState_e stateQ;
  dispState_e stateNext;

  always_comb begin
    strobe.take   = (stateQ == ST_IDLE) && checkReq && imeQ && anyPending;
    strobe.pushPc = (stateQ == ST_PUSH);
    strobe.loadPc = (stateQ == ST_LOAD);
  end

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: if (strobe.take) stateNext = ST_PUSH;
      ST_PUSH: stateNext = ST_LOAD;
      ST_LOAD: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateNext;
  end

  assign dispatchCost = strobe.loadPc ? COST_W'(DISPATCH_CLKS) : '0;

  // R9: push phase is followed immediately by the load phase
  assert_push_then_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pushPc |=> (strobe.loadPc && !strobe.pushPc));

  // R9: load phase only ever comes straight after a push phase
  assert_load_after_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadPc |-> $past(strobe.pushPc));

endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_dispatch_pkg::*;
#(
  parameter int NUM_SRC       = 5,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int VEC_W         = 16,
  parameter int COST_W        = 8,
  parameter int FLAG_ADDR     = 'hFF0F,
  parameter int MASK_ADDR     = 'hFFFF,
  parameter int VEC_BASE      = 'h40,
  parameter int VEC_STEP      = 8,
  parameter int CLK_PER_MCYC  = 4,
  parameter int DISPATCH_MCYC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] periphReq,
  input  logic               imeSet,
  input  logic               imeClr,
  input  logic               checkReq,
  output logic               imeOut,
  output logic               pushPc,
  output logic               loadPc,
  output logic [VEC_W-1:0]   vectorAddr,
  output logic [COST_W-1:0]  dispatchCost
);

  localparam int LAST_VEC = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

  dispStrobe_t strobe;
  logic        anyPending;
  logic        imeQ;

  intr_dispatch_ctrl #(
    .CLK_PER_MCYC (CLK_PER_MCYC),
    .DISPATCH_MCYC(DISPATCH_MCYC),
    .COST_W       (COST_W)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .checkReq    (checkReq),
    .imeQ        (imeQ),
    .anyPending  (anyPending),
    .strobe      (strobe),
    .dispatchCost(dispatchCost)
  );

  intr_dispatch_dp #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_W    (VEC_W),
    .FLAG_ADDR(FLAG_ADDR),
    .MASK_ADDR(MASK_ADDR),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .periphReq (periphReq),
    .imeSet    (imeSet),
    .imeClr    (imeClr),
    .strobe    (strobe),
    .anyPending(anyPending),
    .imeQ      (imeQ),
    .vectorAddr(vectorAddr)
  );

  assign imeOut = imeQ;
  assign pushPc = strobe.pushPc;
  assign loadPc = strobe.loadPc;

  // R4: a push only begins after a check with the master enable set
  assert_start_needs_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pushPc) |-> ($past(checkReq) && $past(imeOut)));

  // R6: the vector presented on load is one of the source slots
  assert_vector_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loadPc |-> ((int'(vectorAddr) >= VEC_BASE) && (int'(vectorAddr) <= LAST_VEC)
                && (((int'(vectorAddr) - VEC_BASE) % VEC_STEP) == 0)));

  // R8: master enable is already low while the push phase runs
  assert_ime_low_in_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pushPc) |-> !imeOut);

endmodule

// File: tb/intr_dispatch_tb.sv
module intr_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [4:0]  periphReq = '0;
  logic        imeSet = 1'b0;
  logic        imeClr = 1'b0;
  logic        checkReq = 1'b0;
  logic        imeOut;
  logic        pushPc;
  logic        loadPc;
  logic [15:0] vectorAddr;
  logic [7:0]  dispatchCost;

  int checks = 0;
  int failures = 0;

  // behavioural reference state
  int mFlags = 0;
  int mEn = 0;
  int mIme = 0;
  int mState = 0;  // 0 idle, 1 push, 2 load
  int mWin = 0;

  always #5 clk = ~clk;

  intr_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .periphReq(periphReq),
    .imeSet(imeSet), .imeClr(imeClr), .checkReq(checkReq), .imeOut(imeOut),
    .pushPc(pushPc), .loadPc(loadPc), .vectorAddr(vectorAddr),
    .dispatchCost(dispatchCost)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int expRead(input int a);
    if (a == 'hFF0F) return 'hE0 | mFlags;
    if (a == 'hFFFF) return mEn;
    return 0;
  endfunction

  task automatic checkOuts();
    chk("R9", "pushPc", int'(pushPc), (mState == 1) ? 1 : 0);
    chk("R9", "loadPc", int'(loadPc), (mState == 2) ? 1 : 0);
    chk("R6", "vectorAddr", int'(vectorAddr), (mState == 2) ? ('h40 + 8 * mWin) : 0);
    chk("R10", "dispatchCost", int'(dispatchCost), (mState == 2) ? 20 : 0);
    chk("R12", "imeOut", int'(imeOut), mIme);
  endtask

  // reference update at a clock edge (R3, R4, R5, R7, R8, R11, R12)
  task automatic modelEdge();
    int pend, take, win, nf;
    pend = mFlags & mEn;
    take = (mState == 0 && checkReq && mIme == 1 && pend != 0) ? 1 : 0;
    win = 0;
    for (int i = 4; i >= 0; i--) if (pend[i]) win = i;
    nf = mFlags;
    if (regWrEn && regAddr == 16'hFF0F) nf = regWrData & 'h1F;
    if (regWrEn && regAddr == 16'hFFFF) mEn = regWrData & 'h1F;
    if (take == 1) nf = nf & ~(1 << win);
    nf = nf | int'(periphReq);
    mFlags = nf;
    if (imeSet) mIme = 1;
    if (imeClr) mIme = 0;
    if (take == 1) mIme = 0;
    if (mState == 1) mState = 2;
    else if (mState == 2) mState = 0;
    else if (take == 1) begin mState = 1; mWin = win; end
  endtask

  // one cycle: drive at negedge, check read (R2), clock, check registered outputs
  task automatic cyc(input int a, input bit we, input int wd, input int per,
                     input bit s, input bit c, input bit cr);
    regAddr = 16'(a); regWrEn = we; regWrData = 8'(wd);
    periphReq = 5'(per); imeSet = s; imeClr = c; checkReq = cr;
    #1;
    chk("R2", "regRdData", int'(regRdData), expRead(a));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOuts();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('h0000, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "pushPc", int'(pushPc), 0);
    chk("R1", "loadPc", int'(loadPc), 0);
    chk("R1", "imeOut", int'(imeOut), 0);
    cyc('hFF0F, 0, 0, 0, 0, 0, 0);   // R1/R2: flags read 0xE0
    cyc('hFFFF, 0, 0, 0, 0, 0, 0);   // R1/R2: enables read 0
    cyc('h1234, 1, 'hFF, 0, 0, 0, 0); // R2: unmapped write/read is inert
    // R3: software writes
    cyc('hFFFF, 1, 'hFF, 0, 0, 0, 0);
    cyc('hFF0F, 1, 'h14, 0, 0, 0, 0);
    cyc('hFF0F, 0, 0, 0, 0, 0, 0);
    // R4: check with master enable off does nothing
    cyc('hFF0F, 0, 0, 0, 0, 0, 1);
    idle(2);
    // R12: set and clear together -> clear wins
    cyc('h0, 0, 0, 0, 1, 1, 0);
    cyc('h0, 0, 0, 0, 1, 0, 0);
    // R5: bits 2 and 4 pending -> timer vector 0x50; R11: check ignored in sequence
    cyc('h0, 0, 0, 0, 0, 0, 1);
    cyc('h0, 0, 0, 0, 1, 0, 1);
    cyc('h0, 0, 0, 0, 0, 0, 1);
    cyc('hFF0F, 0, 0, 0, 0, 0, 1);
    idle(3);
    // R3: peripheral set beats software clear of the same bit
    cyc('hFF0F, 1, 'h00, 'h01, 0, 0, 0);
    cyc('hFF0F, 0, 0, 0, 0, 0, 0);
    // R8: imeSet in the taking cycle still leaves enable off; R6 vector 0x40
    cyc('h0, 0, 0, 0, 1, 0, 0);
    cyc('hFF0F, 1, 'h1F, 0, 1, 0, 1);  // R7: dispatch clear beats software set
    idle(3);
    cyc('hFF0F, 0, 0, 0, 0, 0, 0);
    // R6: each source on its own
    for (int s = 0; s < 5; s++) begin
      cyc('hFF0F, 1, 1 << s, 0, 1, 0, 0);
      cyc('h0, 0, 0, 0, 0, 0, 1);
      idle(3);
    end
    // mixed random phase
    for (int n = 0; n < 6000; n++) begin
      int a, sel;
      sel = int'($urandom % 5);
      a = (sel < 2) ? 'hFF0F : (sel < 4) ? 'hFFFF : 'h00A5;
      cyc(a, ($urandom % 10) < 3, int'($urandom % 256),
          (($urandom % 6) == 0) ? int'($urandom % 32) : 0,
          ($urandom % 5) == 0, ($urandom % 20) == 0, ($urandom % 2) == 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule